// File: doc/BRIEF.md
# Daisy-Chained Serial Configuration Receiver

This block sits at the control end of a 4-output crosspoint that is one tile in a two-dimensional grid of identical tiles. A single serial bus, made of a clock line and a data line, enters the tile at grid position (0,0). The receiver brings both lines into the system clock domain and takes one data bit on every rising edge of the serial clock. It watches the bit stream continuously for a 6-bit start pattern, and once it finds one it collects a full 30-bit control word. The word is sent most significant bit first. It carries the start pattern in bits 29..24, a row address in bits 23..18, a column address in bits 17..12, and four 3-bit output selections in bits 11..0.

A word whose row and column addresses are both zero belongs to this tile. A load word updates the registered selection outputs and pulses a load strobe. A read word only pulses a read strobe. Any other word is passed on to a neighbouring tile. When the row address is nonzero, the word goes out on the column-direction port with the row address reduced by one. When only the column address is nonzero, the word goes out on the row-direction port with the column address reduced by one. Each port sends the whole word, MSB first, and gives one clock pulse per bit.

Top module: `cfg_chain_rx`

## Requirements
- R1: During and after reset, every output selection reads 3'b111 (`sel_o` = 12'hFFF), `load_o` and `read_o` are low, and all four downstream port lines are low.
- R2: A word with start field 6'b011111 and row = col = 0 copies bits 11..0 into `sel_o`, with output 1 in [11:9], output 2 in [8:6], output 3 in [5:3] and output 4 in [2:0]. It also raises `load_o` for exactly one clock.
- R3: A start pattern is recognised at any bit position in the stream. Bits that arrive before it are discarded.
- R4: A 30-bit sequence whose first 6 bits are neither 6'b011111 nor 6'b011110 changes no output and forwards nothing.
- R5: A word with a nonzero row address is sent on the column port (`col_clk_o`/`col_dat_o`) with the row field reduced by one and all other bits unchanged. It goes out MSB first with exactly 30 clock pulses. The data is held stable while the port clock is high, the row port stays idle, and `sel_o` does not change.
- R6: A word with row = 0 and a nonzero column address is sent on the row port (`row_clk_o`/`row_dat_o`) with the column field reduced by one, using the same 30-pulse MSB-first framing. The column port stays idle.
- R7: A word with start field 6'b011110 and row = col = 0 raises `read_o` for exactly one clock, leaves `sel_o` unchanged and forwards nothing.
- R8: After each complete word the 6-bit search window starts empty, so trailing bits of that word can never combine with later bits to form a start pattern.
- R9: Data is taken only at rising edges of `ser_clk_i`. Changes on `ser_dat_i` while the serial clock is high have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk_i | input | 1 | Incoming serial clock (asynchronous) |
| ser_dat_i | input | 1 | Incoming serial data |
| row_clk_o | output | 1 | Row-direction port clock, low when idle |
| row_dat_o | output | 1 | Row-direction port data |
| col_clk_o | output | 1 | Column-direction port clock, low when idle |
| col_dat_o | output | 1 | Column-direction port data |
| sel_o | output | 12 | Four 3-bit output selections, output 1 in the top bits |
| load_o | output | 1 | One-cycle pulse when a load word is accepted |
| read_o | output | 1 | One-cycle pulse when a read word is accepted |

## Verification
The hardest case to reach from the ports is the window-restart rule (R8). A fault there only shows when the tail of one accepted word, together with bits that follow, happens to spell a start pattern. The stimulus builds a load word whose last five bits are 01111, then sends a single 1 followed by a load-shaped body with zero addresses. A receiver that keeps the old bits would accept that body and change `sel_o`. The sampling-edge rule (R9) is reached by flipping the data line in the middle of every serial clock high phase.

// File: rtl/cfg_chain_pkg.sv
// Shared constants and types for the daisy-chained configuration receiver.
// Assumes a 30-bit word: start(6) | row(6) | col(6) | four 3-bit selections.
package cfg_chain_pkg;
    localparam int WORD_W    = 30;
    localparam int START_W   = 6;
    localparam int ADDR_W    = 6;
    localparam int SEL_W     = 3;
    localparam int N_OUT     = 4;
    localparam int CFG_W     = SEL_W * N_OUT;
    localparam int COL_LSB   = CFG_W;
    localparam int ROW_LSB   = COL_LSB + ADDR_W;
    localparam int START_LSB = ROW_LSB + ADDR_W;

    localparam logic [START_W-1:0] START_LOAD = 6'b011111;
    localparam logic [START_W-1:0] START_READ = 6'b011110;
    localparam logic [SEL_W-1:0]   SEL_OFF    = 3'b111;

    typedef enum logic [1:0] {
        PORT_NONE = 2'd0,
        PORT_ROW  = 2'd1,
        PORT_COL  = 2'd2
    } port_e;
endpackage

// File: rtl/cfg_sync_edge.sv
// Brings the asynchronous serial clock and data into the system clock domain
// through matched synchronizer chains, and flags each rising serial-clock edge.
// Assumes each serial clock phase lasts several system clock cycles.
module cfg_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk_i,
    input  logic ser_dat_i,
    output logic bit_vld_o,
    output logic bit_o
);
    logic [STAGES-1:0] clk_q;
    logic [STAGES-1:0] dat_q;
    logic              clk_prev;

    // Synchronizer chains with equal depth keep clock and data aligned.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_q    <= '0;
            dat_q    <= '0;
            clk_prev <= 1'b0;
        end else begin
            clk_q    <= {clk_q[STAGES-2:0], ser_clk_i};
            dat_q    <= {dat_q[STAGES-2:0], ser_dat_i};
            clk_prev <= clk_q[STAGES-1];
        end
    end

    // Rising-edge detect of the synchronized serial clock.
    always_comb begin
        bit_vld_o = clk_q[STAGES-1] & ~clk_prev;
        bit_o     = dat_q[STAGES-1];
    end
endmodule

// File: rtl/cfg_frame_rx.sv
// Searches the bit stream for a start pattern with a sliding window, then
// collects the rest of the word and presents it for one cycle.
// Assumes bit_vld_i pulses for one cycle per received bit.
module cfg_frame_rx
    import cfg_chain_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_vld_i,
    input  logic              bit_i,
    output logic              word_vld_o,
    output logic [WORD_W-1:0] word_o
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] CNT_START = CNT_W'(START_W);

    logic [WORD_W-1:0] sr_q;
    logic [WORD_W-1:0] sr_nxt;
    logic              in_frame_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              start_hit;

    // Next shift value and start-pattern match on the newest six bits.
    always_comb begin
        sr_nxt    = {sr_q[WORD_W-2:0], bit_i};
        start_hit = (sr_nxt[START_W-1:0] == START_LOAD) ||
                    (sr_nxt[START_W-1:0] == START_READ);
    end

    // Hunt / collect state machine; clears the window after every word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q       <= '0;
            in_frame_q <= 1'b0;
            cnt_q      <= '0;
            word_o     <= '0;
            word_vld_o <= 1'b0;
        end else begin
            word_vld_o <= 1'b0;
            if (bit_vld_i) begin
                if (!in_frame_q) begin
                    sr_q <= sr_nxt;
                    if (start_hit) begin
                        in_frame_q <= 1'b1;
                        cnt_q      <= CNT_START;
                    end
                end else if (cnt_q == CNT_LAST) begin
                    word_o     <= sr_nxt;
                    word_vld_o <= 1'b1;
                    sr_q       <= '0;
                    in_frame_q <= 1'b0;
                    cnt_q      <= '0;
                end else begin
                    sr_q  <= sr_nxt;
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // A delivered word always begins with one of the two start patterns.
    assert_word_framed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld_o |-> (word_o[WORD_W-1 -: START_W] == START_LOAD ||
                        word_o[WORD_W-1 -: START_W] == START_READ));

    // The window is empty and hunting right after a word is delivered.
    assert_window_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld_o |-> (sr_q == '0 && !in_frame_q));
endmodule

// File: rtl/cfg_fwd_tx.sv
// Shifts a captured word out MSB first on the row or column port, with one
// clock pulse of 2*HALF_CYC system cycles per bit. The idle port stays low.
// Assumes a new start arrives only while idle; a start while busy is dropped.
module cfg_fwd_tx
    import cfg_chain_pkg::*;
#(
    parameter int HALF_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  port_e             dir_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              busy_o,
    output logic              row_clk_o,
    output logic              row_dat_o,
    output logic              col_clk_o,
    output logic              col_dat_o
);
    localparam int PH_W  = $clog2(2 * HALF_CYC);
    localparam int BIT_W = $clog2(WORD_W);
    localparam int PC_W  = $clog2(WORD_W + 1);
    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(2 * HALF_CYC - 1);
    localparam logic [PH_W-1:0]  PH_HIGH  = PH_W'(HALF_CYC);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WORD_W - 1);

    logic [WORD_W-1:0] sr_q;
    port_e             dir_q;
    logic [PH_W-1:0]   ph_q;
    logic [BIT_W-1:0]  bit_q;
    logic              clk_lvl;

    // Bit timing and shift sequencing for one forwarded word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            sr_q   <= '0;
            dir_q  <= PORT_NONE;
            ph_q   <= '0;
            bit_q  <= '0;
        end else if (!busy_o) begin
            if (start_i && dir_i != PORT_NONE) begin
                busy_o <= 1'b1;
                sr_q   <= word_i;
                dir_q  <= dir_i;
                ph_q   <= '0;
                bit_q  <= '0;
            end
        end else if (ph_q == PH_LAST) begin
            ph_q <= '0;
            sr_q <= {sr_q[WORD_W-2:0], 1'b0};
            if (bit_q == BIT_LAST) begin
                busy_o <= 1'b0;
            end else begin
                bit_q <= bit_q + 1'b1;
            end
        end else begin
            ph_q <= ph_q + 1'b1;
        end
    end

    // Port steering: the clock is high in the second half of each bit.
    always_comb begin
        clk_lvl   = busy_o && (ph_q >= PH_HIGH);
        row_clk_o = clk_lvl && (dir_q == PORT_ROW);
        col_clk_o = clk_lvl && (dir_q == PORT_COL);
        row_dat_o = busy_o && (dir_q == PORT_ROW) && sr_q[WORD_W-1];
        col_dat_o = busy_o && (dir_q == PORT_COL) && sr_q[WORD_W-1];
    end

    // Checker counter: port clock pulses seen during the current transfer.
    logic [PC_W-1:0] pulse_cnt;
    logic            port_clk_d;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_cnt  <= '0;
            port_clk_d <= 1'b0;
        end else begin
            port_clk_d <= row_clk_o | col_clk_o;
            if (!busy_o && start_i) begin
                pulse_cnt <= '0;
            end else if ((row_clk_o | col_clk_o) && !port_clk_d) begin
                pulse_cnt <= pulse_cnt + 1'b1;
            end
        end
    end

    // Data is held while the forwarded clock stays high.
    assert_row_dat_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (row_clk_o && $past(row_clk_o)) |-> $stable(row_dat_o));
    assert_col_dat_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (col_clk_o && $past(col_clk_o)) |-> $stable(col_dat_o));

    // Every transfer ends after exactly one pulse per word bit.
    assert_pulse_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (pulse_cnt == PC_W'(WORD_W)));
endmodule

// File: rtl/cfg_chain_rx.sv
// Top level: synchronizes the serial bus, frames control words, applies
// words addressed to this tile and forwards the rest with the address
// decremented. Assumes the serial bit period exceeds one forwarded word bit
// time, so that a forward finishes before the next word completes.
module cfg_chain_rx
    import cfg_chain_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FWD_HALF    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_clk_i,
    input  logic             ser_dat_i,
    output logic             row_clk_o,
    output logic             row_dat_o,
    output logic             col_clk_o,
    output logic             col_dat_o,
    output logic [CFG_W-1:0] sel_o,
    output logic             load_o,
    output logic             read_o
);
    logic              bit_vld;
    logic              bit_val;
    logic              word_vld;
    logic [WORD_W-1:0] word;
    logic              fwd_start_q;
    port_e             fwd_dir_q;
    logic [WORD_W-1:0] fwd_word_q;
    logic              fwd_busy;

    logic [START_W-1:0] f_start;
    logic [ADDR_W-1:0]  f_row;
    logic [ADDR_W-1:0]  f_col;
    logic [CFG_W-1:0]   f_cfg;

    cfg_sync_edge #(.STAGES(SYNC_STAGES)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_clk_i (ser_clk_i),
        .ser_dat_i (ser_dat_i),
        .bit_vld_o (bit_vld),
        .bit_o     (bit_val)
    );

    cfg_frame_rx frame_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_vld_i  (bit_vld),
        .bit_i      (bit_val),
        .word_vld_o (word_vld),
        .word_o     (word)
    );

    // Field split of the received word.
    always_comb begin
        f_start = word[START_LSB +: START_W];
        f_row   = word[ROW_LSB +: ADDR_W];
        f_col   = word[COL_LSB +: ADDR_W];
        f_cfg   = word[CFG_W-1:0];
    end

    // Routing decision: local load/read, or forward with a decremented address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_o       <= {N_OUT{SEL_OFF}};
            load_o      <= 1'b0;
            read_o      <= 1'b0;
            fwd_start_q <= 1'b0;
            fwd_dir_q   <= PORT_NONE;
            fwd_word_q  <= '0;
        end else begin
            load_o      <= 1'b0;
            read_o      <= 1'b0;
            fwd_start_q <= 1'b0;
            if (word_vld) begin
                if (f_row != '0) begin
                    fwd_word_q  <= {f_start, f_row - 1'b1, f_col, f_cfg};
                    fwd_dir_q   <= PORT_COL;
                    fwd_start_q <= 1'b1;
                end else if (f_col != '0) begin
                    fwd_word_q  <= {f_start, f_row, f_col - 1'b1, f_cfg};
                    fwd_dir_q   <= PORT_ROW;
                    fwd_start_q <= 1'b1;
                end else if (f_start == START_LOAD) begin
                    sel_o  <= f_cfg;
                    load_o <= 1'b1;
                end else begin
                    read_o <= 1'b1;
                end
            end
        end
    end

    cfg_fwd_tx #(.HALF_CYC(FWD_HALF)) fwd_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (fwd_start_q),
        .dir_i     (fwd_dir_q),
        .word_i    (fwd_word_q),
        .busy_o    (fwd_busy),
        .row_clk_o (row_clk_o),
        .row_dat_o (row_dat_o),
        .col_clk_o (col_clk_o),
        .col_dat_o (col_dat_o)
    );

    // The selection register moves only together with a load strobe.
    assert_sel_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !load_o |-> $stable(sel_o));

    // Load and read strobes are single-cycle and never coincide.
    assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_o && read_o));
    assert_load_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> !load_o);

    // Only one downstream port is ever clocked at a time.
    assert_one_port_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(row_clk_o && col_clk_o));

    // A local load or read never starts a forward in the same cycle.
    assert_local_no_fwd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_o || read_o) |-> !fwd_start_q);

    // Both port clocks are low while no forward is running.
    assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !fwd_busy |-> (!row_clk_o && !col_clk_o));
endmodule

// File: tb/cfg_chain_rx_tb_top.sv
// Self-checking bench: a vector table walked by one loop, followed by
// directed tests for reset, window restart and sampling edge.
module cfg_chain_rx_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_dat = 1'b0;
    logic        row_clk, row_dat, col_clk, col_dat;
    logic [11:0] sel;
    logic        load, read;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    cfg_chain_rx dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_clk_i (ser_clk),
        .ser_dat_i (ser_dat),
        .row_clk_o (row_clk),
        .row_dat_o (row_dat),
        .col_clk_o (col_clk),
        .col_dat_o (col_dat),
        .sel_o     (sel),
        .load_o    (load),
        .read_o    (read)
    );

    // Port monitor, sampled on the falling system clock edge.
    int          row_pulses = 0, col_pulses = 0, load_cnt = 0, read_cnt = 0;
    logic [29:0] row_cap = '0, col_cap = '0;
    logic        row_prev = 1'b0, col_prev = 1'b0;
    always @(negedge clk) begin
        if (row_clk && !row_prev) begin
            row_pulses++;
            row_cap = {row_cap[28:0], row_dat};
        end
        if (col_clk && !col_prev) begin
            col_pulses++;
            col_cap = {col_cap[28:0], col_dat};
        end
        row_prev = row_clk;
        col_prev = col_clk;
        if (load) load_cnt++;
        if (read) read_cnt++;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, input bit glitch);
        @(negedge clk) ser_dat = b;
        repeat (3) @(negedge clk);
        ser_clk = 1'b1;
        if (glitch) begin
            repeat (2) @(negedge clk);
            ser_dat = ~b;
            repeat (2) @(negedge clk);
        end else begin
            repeat (4) @(negedge clk);
        end
        ser_clk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_word(input logic [29:0] w, input bit glitch);
        for (int i = 29; i >= 0; i--) send_bit(w[i], glitch);
        repeat (200) @(negedge clk);
    endtask

    typedef struct packed {
        logic [7:0]  pre;
        logic [3:0]  pre_len;
        logic [29:0] word;
        logic [11:0] exp_sel;
        logic        exp_load;
        logic        exp_read;
        logic [1:0]  exp_port;   // 0 none, 1 row port, 2 column port
        logic [29:0] exp_fwd;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        // R2: local load
        '{8'h00, 4'd0, {6'b011111, 6'd0, 6'd0, 12'o0123}, 12'o0123, 1'b1, 1'b0, 2'd0, 30'd0},
        // R3: garbage bits before the start pattern
        '{8'b10110011, 4'd8, {6'b011111, 6'd0, 6'd0, 12'o4567}, 12'o4567, 1'b1, 1'b0, 2'd0, 30'd0},
        // R5: row nonzero, forwarded on column port with row-1
        '{8'h00, 4'd0, {6'b011111, 6'd5, 6'd9, 12'o7000}, 12'o4567, 1'b0, 1'b0, 2'd2,
          {6'b011111, 6'd4, 6'd9, 12'o7000}},
        // R6: column nonzero, forwarded on row port with col-1
        '{8'h00, 4'd0, {6'b011111, 6'd0, 6'd1, 12'o3210}, 12'o4567, 1'b0, 1'b0, 2'd1,
          {6'b011111, 6'd0, 6'd0, 12'o3210}},
        // R7: local read
        '{8'h00, 4'd0, {6'b011110, 6'd0, 6'd0, 12'o1111}, 12'o4567, 1'b0, 1'b1, 2'd0, 30'd0},
        // R5: read word forwarded on column port
        '{8'h00, 4'd0, {6'b011110, 6'd2, 6'd0, 12'o5555}, 12'o4567, 1'b0, 1'b0, 2'd2,
          {6'b011110, 6'd1, 6'd0, 12'o5555}},
        // R4: invalid start field
        '{8'h00, 4'd0, {6'b011101, 6'd0, 6'd0, 12'o0000}, 12'o4567, 1'b0, 1'b0, 2'd0, 30'd0}
    };

    function automatic string vec_tag(input int i);
        case (i)
            0: return "R2";
            1: return "R3";
            2: return "R5";
            3: return "R6";
            4: return "R7";
            5: return "R5";
            default: return "R4";
        endcase
    endfunction

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        int lb, rb, cb, rdb;
        repeat (5) @(negedge clk);
        // R1: state held in reset
        chk(sel == 12'hFFF, "R1", "sel in reset", sel, 12'hFFF);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(sel == 12'hFFF, "R1", "sel after reset", sel, 12'hFFF);
        chk({load, read, row_clk, row_dat, col_clk, col_dat} == 6'b0, "R1", "strobes/ports",
            {load, read, row_clk, row_dat, col_clk, col_dat}, 0);

        // Table walk.
        for (int v = 0; v < NV; v++) begin
            lb = load_cnt; rdb = read_cnt; rb = row_pulses; cb = col_pulses;
            for (int j = int'(VECS[v].pre_len) - 1; j >= 0; j--) send_bit(VECS[v].pre[j], 1'b0);
            send_word(VECS[v].word, 1'b0);
            chk(sel == VECS[v].exp_sel, vec_tag(v), "sel", sel, VECS[v].exp_sel);
            chk(load_cnt - lb == int'(VECS[v].exp_load), vec_tag(v), "load pulses",
                load_cnt - lb, VECS[v].exp_load);
            chk(read_cnt - rdb == int'(VECS[v].exp_read), vec_tag(v), "read pulses",
                read_cnt - rdb, VECS[v].exp_read);
            chk(row_pulses - rb == (VECS[v].exp_port == 2'd1 ? 30 : 0), vec_tag(v),
                "row pulses", row_pulses - rb, (VECS[v].exp_port == 2'd1 ? 30 : 0));
            chk(col_pulses - cb == (VECS[v].exp_port == 2'd2 ? 30 : 0), vec_tag(v),
                "col pulses", col_pulses - cb, (VECS[v].exp_port == 2'd2 ? 30 : 0));
            if (VECS[v].exp_port == 2'd1)
                chk(row_cap == VECS[v].exp_fwd, vec_tag(v), "row word", row_cap, VECS[v].exp_fwd);
            if (VECS[v].exp_port == 2'd2)
                chk(col_cap == VECS[v].exp_fwd, vec_tag(v), "col word", col_cap, VECS[v].exp_fwd);
        end

        // R8: word tail 01111 plus a later 1 must not open a new frame.
        lb = load_cnt;
        send_word({6'b011111, 6'd0, 6'd0, 12'o2617}, 1'b0);
        chk(sel == 12'o2617, "R8", "sel after tail word", sel, 12'o2617);
        send_bit(1'b1, 1'b0);
        send_word({6'd0, 6'd0, 12'o0000}, 1'b0);
        chk(sel == 12'o2617, "R8", "sel after residue bits", sel, 12'o2617);
        chk(load_cnt - lb == 1, "R8", "load pulses", load_cnt - lb, 1);

        // R9: data flipped during every serial clock high phase.
        send_word({6'b011111, 6'd0, 6'd0, 12'o5432}, 1'b1);
        chk(sel == 12'o5432, "R9", "sel with glitching data", sel, 12'o5432);

        // R1: reset in mid-operation returns every output to its off code.
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(sel == 12'hFFF, "R1", "sel after late reset", sel, 12'hFFF);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk({row_clk, col_clk} == 2'b00, "R1", "port clocks idle", {row_clk, col_clk}, 0);

        finish_run();
    end
endmodule